// File: doc/BRIEF.md
# Multi-channel prescaled PWM controller

This block generates a configurable number of pulse-width-modulated outputs (four by default) from one reference clock. Each channel divides the reference clock with a 16-bit prescaler. The prescaler produces ticks, and a 16-bit period counter advances on those ticks. A high-duration compare value sets where the output falls within each period. Every period starts high, so only normal polarity exists.

Software programs the channels through a small word-addressed register port. It has an address, write data, write and read strobes, and read data that is registered for one cycle. New divider, prescaler and high-duration values first go into shadow registers. They reach the counters only when software raises a self-clearing update request, and only at a period boundary. Because of this, a running waveform is never shortened or glitched. Clearing the enable bit stops the channel gracefully: the current period runs to its end, then the output rests low and the divider fields return to fixed defaults.

Top module: `pwm_ctrl`

## Requirements
- R1: Channel n owns a settings word at byte address 8n, holding the period divider in bits 15:0 and the high duration in bits 31:16. It also owns a control word at 8n+4, holding the prescaler in bits 15:0, the update request in bit 30 and the enable in bit 31. Both words read back what is stored.
- R2: A running channel has a period of (divider+1)*(prescaler+1) clock cycles. Its output is high for the first high_duration*(prescaler+1) cycles of each period.
- R3: A high duration of divider+1 or more keeps the output high for the whole period. A high duration of 0 keeps the output low while the channel runs.
- R4: Shadow values are applied only at the first period boundary after an update request. The period in progress completes with the old values, and shadow writes made without a request do not affect the waveform.
- R5: The update bit reads 1 from the request until the values are applied, then reads 0. A request written in the same cycle as an application stays pending for the next boundary.
- R6: After the enable bit is cleared, the output keeps its waveform until the current period ends, then stays low.
- R7: When a disabled channel stops at its boundary, the stored divider becomes 1 and the stored prescaler becomes 0, while the high duration is kept. A software write to a field in that same cycle takes precedence.
- R8: Setting enable on a stopped channel starts a new period on the next cycle with the shadow values, and clears any pending update bit.
- R9: Writes to addresses that are not word aligned, or that lie beyond the last channel, change nothing. Reads from those addresses return 0.
- R10: After reset, every output is low, every settings word reads 0x0000_0001 and every control word reads 0.
- R11: Each channel's waveform is unaffected by the programming of the other channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; data appears on rdata the next cycle |
| rdata | output | 32 | Registered read data |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
Two events can land on the same edge: the hardware applying shadow values at a period boundary, which clears the pending flag, and a software write that raises a new update request. The bench finds a period's start from the output's rising edge. It then counts the known period length and times a second request so that its write strobe is sampled on exactly the boundary edge that applies the first request. It then judges two things: the update bit must still read 1 during the following period, and it must read 0 one period later, once the waveform has taken the new duty.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Field width is fixed by the register layout (16-bit fields).
    parameter int unsigned FIELD_W = 16;

    typedef logic [FIELD_W-1:0] field_t;

    // One channel's timing settings, shadow or active.
    typedef struct packed {
        field_t hi;   // high duration in ticks
        field_t div;  // period divider (period = div+1 ticks)
        field_t pre;  // prescaler (tick = pre+1 clocks)
    } chan_cfg_t;

    localparam field_t DIV_DEFAULT = field_t'(1);
    localparam field_t PRE_DEFAULT = field_t'(0);

    // Control word bit positions (software-visible).
    localparam int unsigned CTRL_UPD_BIT = 30;
    localparam int unsigned CTRL_EN_BIT  = 31;

    // Output level for a given tick position within a period.
    function automatic logic in_high_phase(input field_t pos, input field_t hi);
        return pos < hi;
    endfunction

    function automatic chan_cfg_t reset_cfg();
        chan_cfg_t c;
        c.hi  = '0;
        c.div = DIV_DEFAULT;
        c.pre = PRE_DEFAULT;
        return c;
    endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_set_i,   // write to settings word
    input  logic        wr_ctl_i,   // write to control word
    input  logic [31:0] wdata_i,
    input  logic        commit_i,   // core applied shadow values
    input  logic        halt_i,     // core stopped at a boundary
    output chan_cfg_t   shadow_o,
    output logic        en_o,
    output logic        pend_o,
    output logic [31:0] set_word_o,
    output logic [31:0] ctl_word_o
);

    chan_cfg_t shadow_q;
    logic      en_q;
    logic      pend_q;
    logic      req_now;

    assign req_now = wr_ctl_i && wdata_i[CTRL_UPD_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= reset_cfg();
            en_q     <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            // settings word: software write wins over default reload
            if (wr_set_i) begin
                shadow_q.div <= wdata_i[FIELD_W-1:0];
                shadow_q.hi  <= wdata_i[31:16];
            end else if (halt_i) begin
                shadow_q.div <= DIV_DEFAULT;
            end

            // control word
            if (wr_ctl_i) begin
                shadow_q.pre <= wdata_i[FIELD_W-1:0];
                en_q         <= wdata_i[CTRL_EN_BIT];
            end else if (halt_i) begin
                shadow_q.pre <= PRE_DEFAULT;
            end

            // a fresh request outranks a same-cycle commit
            if (req_now) begin
                pend_q <= 1'b1;
            end else if (commit_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign shadow_o   = shadow_q;
    assign en_o       = en_q;
    assign pend_o     = pend_q;
    assign set_word_o = {shadow_q.hi, shadow_q.div};
    assign ctl_word_o = {en_q, pend_q, 14'd0, shadow_q.pre};

    // R5: a commit without a competing request leaves nothing pending
    a_r5_commit_clears: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !req_now) |=> !pend_q);

    // R5: a request is always visible on the following cycle
    a_r5_request_wins: assert property (@(posedge clk) disable iff (rst)
        req_now |=> pend_q);

    // R7: stopping reloads the default divider unless software writes it
    a_r7_div_reload: assert property (@(posedge clk) disable iff (rst)
        (halt_i && !wr_set_i) |=> (shadow_q.div == DIV_DEFAULT));

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      pend_i,
    input  chan_cfg_t shadow_i,
    output logic      commit_o,
    output logic      halt_o,
    output logic      pwm_o
);

    chan_cfg_t act_q;
    logic      run_q;
    field_t    pre_cnt_q;
    field_t    per_cnt_q;
    logic      tick;
    logic      last;

    assign tick = run_q && (pre_cnt_q == act_q.pre);
    assign last = tick && (per_cnt_q == act_q.div);

    assign commit_o = (!run_q && en_i) || (last && en_i && pend_i);
    assign halt_o   = last && !en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            act_q     <= reset_cfg();
            pre_cnt_q <= '0;
            per_cnt_q <= '0;
        end else if (!run_q) begin
            if (en_i) begin
                run_q     <= 1'b1;
                act_q     <= shadow_i;
                pre_cnt_q <= '0;
                per_cnt_q <= '0;
            end
        end else begin
            pre_cnt_q <= tick ? '0 : pre_cnt_q + field_t'(1);
            if (tick) begin
                per_cnt_q <= last ? '0 : per_cnt_q + field_t'(1);
            end
            if (last) begin
                if (!en_i) begin
                    run_q <= 1'b0;
                end else if (pend_i) begin
                    act_q <= shadow_i;
                end
            end
        end
    end

    assign pwm_o = run_q && in_high_phase(per_cnt_q, act_q.hi);

    // R6: a running channel only stops on the last cycle of a period
    a_r6_stop_at_end: assert property (@(posedge clk) disable iff (rst)
        (run_q && !last) |=> run_q);

    // R4: active settings never change inside a period
    a_r4_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        (run_q && !last) |=> $stable(act_q));

    // R2: counters stay inside the active period geometry
    a_r2_count_bounds: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ((per_cnt_q <= act_q.div) && (pre_cnt_q <= act_q.pre)));

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
    import pwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    localparam int unsigned CH_STRIDE_LG = 3;  // 8 bytes per channel

    logic [ADDR_W-1:0] ch_idx;
    logic              mapped;
    logic              sel_ctl;
    logic [31:0]       set_word [NUM_CH];
    logic [31:0]       ctl_word [NUM_CH];
    logic [31:0]       rd_mux;
    logic [31:0]       rdata_q;

    assign ch_idx  = addr >> CH_STRIDE_LG;
    assign sel_ctl = addr[2];
    assign mapped  = (addr[1:0] == 2'b00) && (ch_idx < ADDR_W'(NUM_CH));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_cfg_t shadow;
        logic      en;
        logic      pend;
        logic      commit;
        logic      halt;
        logic      hit;

        assign hit = wr_en && mapped && (ch_idx == ADDR_W'(g));

        pwm_chan_regs u_regs (
            .clk        (clk),
            .rst        (rst),
            .wr_set_i   (hit && !sel_ctl),
            .wr_ctl_i   (hit && sel_ctl),
            .wdata_i    (wdata),
            .commit_i   (commit),
            .halt_i     (halt),
            .shadow_o   (shadow),
            .en_o       (en),
            .pend_o     (pend),
            .set_word_o (set_word[g]),
            .ctl_word_o (ctl_word[g])
        );

        pwm_chan_core u_core (
            .clk      (clk),
            .rst      (rst),
            .en_i     (en),
            .pend_i   (pend),
            .shadow_i (shadow),
            .commit_o (commit),
            .halt_o   (halt),
            .pwm_o    (pwm_o[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (mapped && (ch_idx == ADDR_W'(i))) begin
                rd_mux = sel_ctl ? ctl_word[i] : set_word[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata = rdata_q;

    // R9: reads outside the map return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !mapped) |=> (rdata == 32'd0));

endmodule

// File: tb/tb_pwm_ctrl.sv
module tb_pwm_ctrl;

    localparam int unsigned NUM_CH = 4;
    localparam int unsigned ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [31:0]       rdata;
    logic [NUM_CH-1:0] pwm_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pwm_o(pwm_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // called at a negedge; strobe is sampled on the next posedge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // returns at the first negedge where the output has just gone high
    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_o[ch];
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (!prev && pwm_o[ch]) return;
            prev = pwm_o[ch];
        end
        $display("no rising edge seen on channel %0d", ch);
    endtask

    // called at a rise sample; returns at the next rise sample
    task automatic measure(input int ch, output int h, output int p);
        int l;
        h = 1; l = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (pwm_o[ch]) h++; else break;
        end
        l = 1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (!pwm_o[ch]) l++; else break;
        end
        p = h + l;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R10 outputs low", 32'(pwm_o), 32'd0);
        rd(8'h00, d); chk("R10 settings word", d, 32'h0000_0001);
        rd(8'h04, d); chk("R10 control word", d, 32'h0000_0000);
        rd(8'h1C, d); chk("R10 last control word", d, 32'h0000_0000);
    endtask

    task automatic t_basic();
        int h, p;
        logic [31:0] d;
        wr(8'h00, {16'd2, 16'd3});
        wr(8'h04, 32'hC000_0001);
        wait_rise(0);
        measure(0, h, p);
        chk("R2 high length", 32'(h), 32'd4);
        chk("R2 period length", 32'(p), 32'd8);
        rd(8'h04, d); chk("R8 update cleared on start", d, 32'h8000_0001);
        rd(8'h00, d); chk("R1 settings readback", d, {16'd2, 16'd3});
    endtask

    task automatic t_indep();
        int h, p;
        wr(8'h10, {16'd1, 16'd4});
        wr(8'h14, 32'h8000_0000);  // enable only, no request
        wait_rise(2);
        measure(2, h, p);
        chk("R8 idle start high", 32'(h), 32'd1);
        chk("R11 channel 2 period", 32'(p), 32'd5);
        wait_rise(0);
        measure(0, h, p);
        chk("R11 channel 0 unchanged", 32'(p * 100 + h), 32'd804);
        chk("R11 channels 1 and 3 idle", 32'({pwm_o[3], pwm_o[1]}), 32'd0);
        wr(8'h14, 32'h0000_0000);
    endtask

    task automatic t_update();
        int h, p, h2, p2;
        logic [31:0] d_mid, d;
        wr(8'h00, {16'd3, 16'd5});  // shadow only
        wait_rise(0);
        measure(0, h, p);
        measure(0, h, p);
        chk("R4 shadow alone inert", 32'(p * 100 + h), 32'd804);
        // now at a rise: request update while this period runs
        fork
            measure(0, h, p);
            begin
                wr(8'h04, 32'hC000_0001);
                rd(8'h04, d_mid);
            end
        join
        chk("R4 running period keeps old values", 32'(p * 100 + h), 32'd804);
        chk("R5 update reads 1 while pending", d_mid, 32'hC000_0001);
        measure(0, h2, p2);
        chk("R4 new high after boundary", 32'(h2), 32'd6);
        chk("R2 new period after boundary", 32'(p2), 32'd12);
        rd(8'h04, d); chk("R5 update self-cleared", d, 32'h8000_0001);
    endtask

    task automatic t_extremes();
        int lows, highs;
        wr(8'h10, {16'd5, 16'd4});  // hi == div+1
        wr(8'h14, 32'hC000_0000);
        repeat (12) @(negedge clk);
        lows = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!pwm_o[2]) lows++;
        end
        chk("R3 full duty stays high", 32'(lows), 32'd0);
        wr(8'h10, {16'd0, 16'd4});
        wr(8'h14, 32'hC000_0000);
        repeat (12) @(negedge clk);
        highs = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_o[2]) highs++;
        end
        chk("R3 zero duty stays low", 32'(highs), 32'd0);
        wr(8'h14, 32'h0000_0000);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_disable();
        int hc;
        logic [31:0] d;
        wait_rise(0);  // hi=3 div=5 pre=1: 6 high, 12 period
        fork
            wr(8'h04, 32'h0000_0001);  // clear enable, prescaler written 1
            begin
                hc = 1;
                for (int k = 0; k < 60; k++) begin
                    @(negedge clk);
                    if (pwm_o[0]) hc++;
                end
            end
        join
        chk("R6 high phase completed once", 32'(hc), 32'd6);
        chk("R6 output rests low", 32'(pwm_o[0]), 32'd0);
        rd(8'h00, d); chk("R7 divider reloaded, high kept", d, {16'd3, 16'd1});
        rd(8'h04, d); chk("R7 prescaler reloaded", d, 32'h0000_0000);
    endtask

    task automatic t_reenable();
        int h, p;
        wr(8'h00, {16'd1, 16'd2});
        wr(8'h04, 32'h8000_0000);
        wait_rise(0);
        measure(0, h, p);
        chk("R8 restart uses shadow", 32'(p * 100 + h), 32'd301);
    endtask

    task automatic t_unmapped();
        int h, p;
        logic [31:0] d;
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h0D, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R9 read beyond channels", d, 32'd0);
        rd(8'h02, d); chk("R9 unaligned read", d, 32'd0);
        rd(8'h00, d); chk("R9 channel 0 settings untouched", d, {16'd1, 16'd2});
        rd(8'h0C, d); chk("R9 channel 1 control untouched", d, 32'd0);
        wait_rise(0);
        measure(0, h, p);
        chk("R9 waveform untouched", 32'(p * 100 + h), 32'd301);
    endtask

    task automatic t_collide();
        int h, p;
        logic [31:0] d;
        wr(8'h00, {16'd2, 16'd3});
        wr(8'h04, 32'hC000_0001);
        wait_rise(0);
        wait_rise(0);  // period 8: rise seen one negedge after boundary edge
        wr(8'h00, {16'd1, 16'd3});   // sampled boundary+1
        wr(8'h04, 32'hC000_0001);    // request, sampled boundary+2
        repeat (5) @(negedge clk);
        wr(8'h04, 32'hC000_0001);    // sampled on the next boundary edge
        rd(8'h04, d);
        chk("R5 same-cycle request stays pending", d, 32'hC000_0001);
        wait_rise(0);
        measure(0, h, p);
        chk("R4 committed duty after collision", 32'(p * 100 + h), 32'd802);
        rd(8'h04, d);
        chk("R5 pending cleared one period later", d, 32'h8000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_indep();
        t_update();
        t_extremes();
        t_disable();
        t_reenable();
        t_unmapped();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule